// File: doc/BRIEF.md
# Lockable Way Replacement Controller

This block chooses which way of a set-associative cache receives a newly allocated line. Each set has its own round-robin pointer and its own vector of lock bits. An ordinary fill takes the first way at or after the pointer that is not locked, then moves the pointer to the way after the one it chose. Locked lines therefore stay resident until software releases them.

A fill made while the lock control is on is a pinning fill. It ignores the pointer and always goes into one of two designated ways: way A, or way B when the select bit is set. That way is marked locked. The lock enable comes from whichever cache this instance serves, and the select bit is shared. A per-set unlock command clears every lock bit of one set.

The answer for a request appears on the registered outputs one cycle after the request. Tag and data arrays and the bus side belong to the surrounding cache and are not part of this block.

Top module: `wayrep_ctrl`

## Requirements
- R1: A response is presented exactly one clock after an allocate request: `victim_valid` is 1 in the cycle after `alloc_valid` was 1, and 0 in the cycle after `alloc_valid` was 0. Without a request, `victim_way`, `victim_lock` and `no_victim` are 0.
- R2: After reset every output is 0, every lock bit is clear and every pointer is at way 0, so the first ordinary fill to any set returns way 0.
- R3: Repeated ordinary fills to a set with no locks return ways 0, 1, 2, ..., WAYS-1, 0, ... in that order. Each set keeps its own pointer, and fills to one set do not move the pointer of another.
- R4: A pinning fill (`lock_en`=1) returns way `LOCK_WAY_A` (default 0) when `lock_sel`=0 and way `LOCK_WAY_B` (default 1) when `lock_sel`=1, with `victim_lock`=1 and `no_victim`=0. It marks that way locked, also when it was already locked, and leaves the pointer unchanged.
- R5: An ordinary fill (`lock_en`=0, `lock_sel` ignored) never returns a locked way. It returns the first unlocked way found scanning upward from the pointer with wrap-around, sets the pointer to that way plus one modulo WAYS, and reports `victim_lock`=0.
- R6: An ordinary fill to a set whose ways are all locked reports `no_victim`=1 with `victim_way`=0 and `victim_lock`=0, and leaves the pointer unchanged.
- R7: An unlock command clears all lock bits of `unlock_set`. It leaves every pointer and the lock bits of all other sets unchanged.
- R8: When an allocate and an unlock name the same set in the same cycle, the allocate is decided on the lock bits from before the unlock and its pointer update still takes effect. Afterwards all lock bits of that set are clear, including one a pinning fill would have set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate request this cycle |
| alloc_set | input | $clog2(SETS) | Set index of the allocate request |
| lock_en | input | 1 | Make this allocate a pinning fill |
| lock_sel | input | 1 | Pin target: 0 way A, 1 way B |
| unlock_valid | input | 1 | Clear the lock bits of one set |
| unlock_set | input | $clog2(SETS) | Set index for the unlock |
| victim_valid | output | 1 | Response valid, one cycle after the request |
| victim_way | output | $clog2(WAYS) | Chosen way |
| victim_lock | output | 1 | The chosen way is being locked |
| no_victim | output | 1 | All ways locked; nothing is evicted |

## Verification
The assertions assume that WAYS is a power of two and that both pin ways are below WAYS, so that pointer arithmetic wraps cleanly. They also assume `alloc_set` and `unlock_set` are in range whenever their valid bit is high. The unlock property reads the lock vector through the allocate index, so it makes claims only when the next allocate index names the cleared set.

The stimulus keeps within these assumptions by instantiating two legal configurations, four ways with eight sets and two ways with four sets, and driving only in-range indices to both. In the two-way configuration both ways are pinnable, which is what makes the all-locked case of R6 reachable. Directed sequences and a long seeded random run are compared against a behavioural model in the bench.

// File: rtl/wayrep_pkg.sv
package wayrep_pkg;

    typedef enum logic [1:0] {
        REQ_IDLE = 2'd0,
        REQ_FILL = 2'd1,
        REQ_PIN  = 2'd2
    } req_kind_e;

    typedef struct packed {
        logic valid;
        logic lock;
        logic none;
    } resp_flags_t;

    function automatic req_kind_e classify_req(input logic valid, input logic pin);
        if (!valid)
            return REQ_IDLE;
        else if (pin)
            return REQ_PIN;
        else
            return REQ_FILL;
    endfunction

    function automatic resp_flags_t make_flags(input req_kind_e kind, input logic found);
        resp_flags_t f;
        f.valid = (kind != REQ_IDLE);
        f.lock  = (kind == REQ_PIN);
        f.none  = (kind == REQ_FILL) && !found;
        return f;
    endfunction

endpackage

// File: rtl/wayrep_picker.sv
module wayrep_picker #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  mask,
    input  logic [WAY_W-1:0] ptr,
    output logic [WAY_W-1:0] way,
    output logic             found
);
    logic [WAY_W-1:0] idx;

    // Scan from the farthest offset back to the pointer so the nearest free way wins.
    always_comb begin
        found = 1'b0;
        way   = '0;
        idx   = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            idx = ptr + WAY_W'(i);
            if (!mask[idx]) begin
                found = 1'b1;
                way   = idx;
            end
        end
    end
endmodule

// File: rtl/wayrep_set_state.sv
module wayrep_set_state #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ptr_we,
    input  logic [WAY_W-1:0] ptr_d,
    input  logic             pin_we,
    input  logic [WAY_W-1:0] pin_way,
    input  logic             clr,
    output logic [WAY_W-1:0] ptr_q,
    output logic [WAYS-1:0]  mask_q
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (ptr_we)
            ptr_q <= ptr_d;
    end

    // A clear in the same cycle as a pin wins.
    always_ff @(posedge clk) begin
        if (rst || clr)
            mask_q <= '0;
        else if (pin_we)
            mask_q[pin_way] <= 1'b1;
    end
endmodule

// File: rtl/wayrep_store.sv
module wayrep_store #(
    parameter int SETS  = 8,
    parameter int WAYS  = 4,
    parameter int SET_W = $clog2(SETS),
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] acc_set,
    input  logic             ptr_we,
    input  logic [WAY_W-1:0] ptr_d,
    input  logic             pin_we,
    input  logic [WAY_W-1:0] pin_way,
    input  logic             clr_we,
    input  logic [SET_W-1:0] clr_set,
    output logic [WAY_W-1:0] rd_ptr,
    output logic [WAYS-1:0]  rd_mask
);
    logic [WAY_W-1:0] ptr_arr  [SETS];
    logic [WAYS-1:0]  mask_arr [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic hit_acc;
        logic hit_clr;
        assign hit_acc = (acc_set == SET_W'(s));
        assign hit_clr = clr_we && (clr_set == SET_W'(s));

        wayrep_set_state #(.WAYS(WAYS), .WAY_W(WAY_W)) st_i (
            .clk     (clk),
            .rst     (rst),
            .ptr_we  (ptr_we && hit_acc),
            .ptr_d   (ptr_d),
            .pin_we  (pin_we && hit_acc),
            .pin_way (pin_way),
            .clr     (hit_clr),
            .ptr_q   (ptr_arr[s]),
            .mask_q  (mask_arr[s])
        );
    end

    assign rd_ptr  = ptr_arr[acc_set];
    assign rd_mask = mask_arr[acc_set];
endmodule

// File: rtl/wayrep_ctrl.sv
module wayrep_ctrl
    import wayrep_pkg::*;
#(
    parameter int SETS       = 8,
    parameter int WAYS       = 4,
    parameter int LOCK_WAY_A = 0,
    parameter int LOCK_WAY_B = 1,
    localparam int SET_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_valid,
    input  logic [SET_W-1:0] alloc_set,
    input  logic             lock_en,
    input  logic             lock_sel,
    input  logic             unlock_valid,
    input  logic [SET_W-1:0] unlock_set,
    output logic             victim_valid,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_lock,
    output logic             no_victim
);
    localparam logic [WAY_W-1:0] PIN_A = WAY_W'(LOCK_WAY_A);
    localparam logic [WAY_W-1:0] PIN_B = WAY_W'(LOCK_WAY_B);

    req_kind_e        kind;
    resp_flags_t      flags_d;
    logic [WAY_W-1:0] cur_ptr;
    logic [WAYS-1:0]  cur_mask;
    logic [WAY_W-1:0] pick_way;
    logic             pick_found;
    logic [WAY_W-1:0] pin_way;
    logic [WAY_W-1:0] way_d;

    assign kind    = classify_req(alloc_valid, lock_en);
    assign pin_way = lock_sel ? PIN_B : PIN_A;
    assign flags_d = make_flags(kind, pick_found);

    wayrep_store #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) store_i (
        .clk     (clk),
        .rst     (rst),
        .acc_set (alloc_set),
        .ptr_we  ((kind == REQ_FILL) && pick_found),
        .ptr_d   (pick_way + WAY_W'(1)),
        .pin_we  (kind == REQ_PIN),
        .pin_way (pin_way),
        .clr_we  (unlock_valid),
        .clr_set (unlock_set),
        .rd_ptr  (cur_ptr),
        .rd_mask (cur_mask)
    );

    wayrep_picker #(.WAYS(WAYS), .WAY_W(WAY_W)) pick_i (
        .mask  (cur_mask),
        .ptr   (cur_ptr),
        .way   (pick_way),
        .found (pick_found)
    );

    always_comb begin
        unique case (kind)
            REQ_PIN:  way_d = pin_way;
            REQ_FILL: way_d = pick_found ? pick_way : '0;
            default:  way_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            victim_valid <= 1'b0;
            victim_way   <= '0;
            victim_lock  <= 1'b0;
            no_victim    <= 1'b0;
        end else begin
            victim_valid <= flags_d.valid;
            victim_way   <= way_d;
            victim_lock  <= flags_d.lock;
            no_victim    <= flags_d.none;
        end
    end
endmodule

// File: rtl/wayrep_ctrl_chk.sv
module wayrep_ctrl_chk #(
    parameter int SETS       = 8,
    parameter int WAYS       = 4,
    parameter int LOCK_WAY_A = 0,
    parameter int LOCK_WAY_B = 1,
    localparam int SET_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_valid,
    input logic [SET_W-1:0] alloc_set,
    input logic             lock_en,
    input logic             lock_sel,
    input logic             unlock_valid,
    input logic [SET_W-1:0] unlock_set,
    input logic             victim_valid,
    input logic [WAY_W-1:0] victim_way,
    input logic             victim_lock,
    input logic             no_victim,
    input logic [WAYS-1:0]  cur_mask
);
    localparam logic [WAY_W-1:0] PA = WAY_W'(LOCK_WAY_A);
    localparam logic [WAY_W-1:0] PB = WAY_W'(LOCK_WAY_B);

    logic [WAYS-1:0] mask_q;
    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= cur_mask;
    end

    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |=> victim_valid); // R1
    AST_RESP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !alloc_valid |=> !victim_valid && !victim_lock && !no_victim); // R1
    AST_PIN_TARGET: assert property (@(posedge clk) disable iff (rst)
        alloc_valid && lock_en |=> victim_lock && !no_victim
            && (victim_way == ($past(lock_sel) ? PB : PA))); // R4
    AST_FILL_SKIPS_LOCKED: assert property (@(posedge clk) disable iff (rst)
        alloc_valid && !lock_en && !(&cur_mask) |=> !victim_lock && !no_victim
            && !mask_q[victim_way]); // R5
    AST_NONE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        alloc_valid && !lock_en && (&cur_mask) |=> no_victim && !victim_lock
            && (victim_way == '0)); // R6
    AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        unlock_valid |=> (alloc_set != $past(unlock_set)) || (cur_mask == '0)); // R7
endmodule

bind wayrep_ctrl wayrep_ctrl_chk #(
    .SETS(SETS), .WAYS(WAYS), .LOCK_WAY_A(LOCK_WAY_A), .LOCK_WAY_B(LOCK_WAY_B)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .alloc_valid  (alloc_valid),
    .alloc_set    (alloc_set),
    .lock_en      (lock_en),
    .lock_sel     (lock_sel),
    .unlock_valid (unlock_valid),
    .unlock_set   (unlock_set),
    .victim_valid (victim_valid),
    .victim_way   (victim_way),
    .victim_lock  (victim_lock),
    .no_victim    (no_victim),
    .cur_mask     (cur_mask)
);

// File: tb/wayrep_ctrl_tb_top.sv
module wayrep_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       av = 1'b0, le = 1'b0, ls = 1'b0, uv = 1'b0;
    logic [2:0] aset = '0, uset = '0;

    logic       v0, l0, n0, v1, l1, n1;
    logic [1:0] w0;
    logic [0:0] w1;

    wayrep_ctrl #(.SETS(8), .WAYS(4)) dut_i (
        .clk(clk), .rst(rst), .alloc_valid(av), .alloc_set(aset),
        .lock_en(le), .lock_sel(ls), .unlock_valid(uv), .unlock_set(uset),
        .victim_valid(v0), .victim_way(w0), .victim_lock(l0), .no_victim(n0));

    wayrep_ctrl #(.SETS(4), .WAYS(2)) dut_small_i (
        .clk(clk), .rst(rst), .alloc_valid(av), .alloc_set(aset[1:0]),
        .lock_en(le), .lock_sel(ls), .unlock_valid(uv), .unlock_set(uset[1:0]),
        .victim_valid(v1), .victim_way(w1), .victim_lock(l1), .no_victim(n1));

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    int  NW[2] = '{4, 2};
    int  NS[2] = '{8, 4};
    int  m_ptr[2][8];
    bit  m_lk[2][8][4];

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got {valid,way,lock,none}=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic model(int c, bit a, int s, bit pin, bit sel, bit u, int us,
                         output logic [4:0] exp);
        int  w;
        bit  none;
        w = 0;
        none = 1'b0;
        s  = s % NS[c];
        us = us % NS[c];
        if (a) begin
            if (pin) begin
                w = sel ? 1 : 0;
                m_lk[c][s][w] = 1'b1;
            end else begin
                none = 1'b1;
                for (int i = 0; i < NW[c]; i++) begin
                    int k;
                    k = (m_ptr[c][s] + i) % NW[c];
                    if (none && !m_lk[c][s][k]) begin
                        w = k;
                        none = 1'b0;
                    end
                end
                if (!none) m_ptr[c][s] = (w + 1) % NW[c];
            end
        end
        if (u) for (int k = 0; k < 4; k++) m_lk[c][us][k] = 1'b0;
        exp = {a, w[1:0], a && pin, none};
    endtask

    // One operation: idle check, drive for one edge, check both configurations.
    task automatic op(string tag, bit a, int s, bit pin, bit sel, bit u, int us);
        logic [4:0] e0, e1;
        @(negedge clk);
        check("R1 idle", {v0, w0, l0, n0}, 5'b0);
        check("R1 idle", {v1, 1'b0, w1, l1, n1}, 5'b0);
        av = a; aset = 3'(s); le = pin; ls = sel; uv = u; uset = 3'(us);
        model(0, a, s, pin, sel, u, us, e0);
        model(1, a, s, pin, sel, u, us, e1);
        @(negedge clk);
        check(tag, {v0, w0, l0, n0}, e0);
        check(tag, {v1, 1'b0, w1, l1, n1}, e1);
        av = 1'b0; le = 1'b0; ls = 1'b0; uv = 1'b0;
    endtask

    task automatic fill(string tag, int s);
        op(tag, 1'b1, s, 1'b0, 1'b0, 1'b0, 0);
    endtask

    task automatic pin(string tag, int s, bit sel);
        op(tag, 1'b1, s, 1'b1, sel, 1'b0, 0);
    endtask

    task automatic unlock(string tag, int s);
        op(tag, 1'b0, 0, 1'b0, 1'b0, 1'b1, s);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 reset", {v0, w0, l0, n0}, 5'b0);
        check("R2 reset", {v1, 1'b0, w1, l1, n1}, 5'b0);

        // R2 / R3: each set starts at way 0 and cycles on its own pointer.
        for (int s = 0; s < 8; s++) fill("R2", s);
        for (int s = 0; s < 8; s++)
            for (int k = 0; k < 5; k++) fill("R3", s);
        // R3: lock_sel has no effect on an ordinary fill.
        op("R3 sel ignored", 1'b1, 3, 1'b0, 1'b1, 1'b0, 0);

        // R4: pin into A and B, repin an already locked way.
        pin("R4 way A", 2, 1'b0);
        pin("R4 way B", 6, 1'b1);
        pin("R4 repin", 2, 1'b0);
        // R5: fills skip the pinned ways.
        for (int k = 0; k < 6; k++) fill("R5", 2);
        pin("R4 way B", 2, 1'b1);
        for (int k = 0; k < 6; k++) fill("R5", 2);
        // R6: small configuration is fully locked on set 2.
        fill("R6", 2);
        fill("R6", 6);
        // R7: unlock set 2 only; set 6 keeps its lock.
        unlock("R7", 2);
        for (int k = 0; k < 5; k++) fill("R7", 2);
        for (int k = 0; k < 3; k++) fill("R7 other set", 6);
        // R8: pin and unlock on the same set in one cycle.
        op("R8 pin+unlock", 1'b1, 5, 1'b1, 1'b1, 1'b1, 5);
        for (int k = 0; k < 4; k++) fill("R8", 5);
        pin("R8 setup", 4, 1'b0);
        pin("R8 setup", 4, 1'b1);
        op("R8 fill+unlock", 1'b1, 4, 1'b0, 1'b0, 1'b1, 4);
        for (int k = 0; k < 4; k++) fill("R8", 4);

        // Seeded random mix against the model.
        for (int n = 0; n < 3000; n++) begin
            int  r;
            bit  a, p, s2, u;
            r  = $urandom_range(0, 99);
            a  = (r < 85);
            p  = ($urandom_range(0, 99) < 25);
            s2 = $urandom_range(0, 1);
            u  = ($urandom_range(0, 99) < 12);
            op(p ? "R4 rand" : "R5 rand", a, $urandom_range(0, 7), p, s2, u,
               $urandom_range(0, 7));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule